// File: doc/BRIEF.md
# Banked Register Exception Entry Unit

This block holds the processor state that changes when an exception is taken in a core with per-mode banked registers. That state is the status word (a 5-bit mode field and an interrupt-disable bit), the saved-status register, the working registers r29 and r30, and the program counter r31. It also holds one bank of (r29, r30, saved status) for each mode group. An exception request carries a cause code, the high-vector select bit and the PC of the interrupted instruction. The request is offered on a valid/ready handshake. The block then does the following:
- It maps the cause to a target mode.
- It swaps the banked registers, unless the target mode equals the current one.
- It copies the whole pre-entry status word into the saved-status register.
- It writes the new mode and sets interrupt-disable.
- It stores the PC as the return address in r30.
- It loads r31 with the vector address.

The request side follows valid/ready rules. `exc_ready_o` is low while reset is held and rises at the first clock edge after reset is released. After that it stays high, because an entry always completes in one cycle. A request transfers on any edge where valid and ready are both high. Holding valid high across several edges makes several entries, one per edge. Decode and the return path are handled elsewhere.

Top module: `exc_entry_unit`

## Requirements
- R1: Cause codes map to target modes: 0 (software call) to privileged 5'h13; 1 (instruction abort) and 2 (data abort) to trap 5'h17; 3 (interrupt) to interrupt 5'h12.
- R2: The vector is the base plus a cause offset. The base is 32'h0000_0000, or 32'hFFFF_0000 when `hi_vec_i` is 1. The offsets are 0x08 for cause 0, 0x0C for cause 1, 0x10 for cause 2 and 0x18 for cause 3.
- R3: After entry, status bits [4:0] hold the new mode, bit 7 (interrupt disable) is 1, and all other bits keep their pre-entry values.
- R4: After entry, the saved-status output equals the full status word from before the entry.
- R5: After entry, r30 holds the PC presented with the request and r31 holds the vector from R2.
- R6: When the target mode differs from the current one, the current r29, r30 and saved status are stored in the old mode's bank, and r29 is reloaded from the new mode's bank. Bank indices are: user 5'h10 and system 5'h1F share 0, privileged 1, trap 2, interrupt 3, extension 5'h1B 4. Each bank's r29 resets to R29_BASE plus its index.
- R7: When the target mode equals the current one, no bank is read or written and r29 keeps its value.
- R8: A cause code of 4 to 7 is consumed without changing any state. `bad_cause_o` pulses for one cycle and no entry-done pulse is given.
- R9: While the current mode field matches no bank, `mode_err_o` is 1 and accepted requests change no state.
- R10: `exc_ready_o` is 0 in reset and 1 from the first edge after reset is released. `entry_done_o` pulses for exactly the cycle after each completed entry.
- R11: In reset, the mode field is RESET_MODE, the other status bits are RESET_STATUS, r30, r31 and saved status are 0, and r29 is its mode's bank seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_valid_i | input | 1 | Exception request valid |
| exc_ready_o | output | 1 | Unit can accept a request |
| exc_cause_i | input | 3 | Exception cause code |
| hi_vec_i | input | 1 | Selects the high vector base |
| exc_pc_i | input | 32 | PC of the interrupted instruction |
| status_o | output | 32 | Current status word |
| saved_status_o | output | 32 | Saved-status register |
| r29_o | output | 32 | Working r29 |
| r30_o | output | 32 | Working r30 (return address) |
| r31_o | output | 32 | Program counter |
| entry_done_o | output | 1 | One-cycle pulse after an entry |
| bad_cause_o | output | 1 | One-cycle pulse after an illegal cause |
| mode_err_o | output | 1 | Current mode matches no bank |

## Verification
The main instance uses the defaults: reset in user mode, RESET_STATUS 32'h6000_0000 and bank seeds from 32'h1000. Because the seeds are distinct, every r29 reload shows which bank was read. A chain of entries moves through privileged, interrupt and trap and back again, which covers both the swap and the same-mode cases. A second instance has RESET_MODE set to 5'h05, a code that no bank decodes. It is fed the same request stream, so the error state can be reached without any software access.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int NUM_BANKS = 5;
  localparam int BIDX_W    = $clog2(NUM_BANKS);

  localparam logic [4:0] MODE_USER = 5'h10;
  localparam logic [4:0] MODE_SYS  = 5'h1F;
  localparam logic [4:0] MODE_PRIV = 5'h13;
  localparam logic [4:0] MODE_TRAP = 5'h17;
  localparam logic [4:0] MODE_INTR = 5'h12;
  localparam logic [4:0] MODE_EXT  = 5'h1B;

  localparam logic [2:0] CAUSE_SWCALL = 3'd0;
  localparam logic [2:0] CAUSE_IABORT = 3'd1;
  localparam logic [2:0] CAUSE_DABORT = 3'd2;
  localparam logic [2:0] CAUSE_IRQ    = 3'd3;

  localparam int INTDIS_BIT = 7;

  typedef struct packed {
    logic              valid;
    logic [BIDX_W-1:0] idx;
  } bank_sel_t;

  function automatic bank_sel_t mode_to_bank(input logic [4:0] m);
    bank_sel_t s;
    s.valid = 1'b1;
    case (m)
      MODE_USER, MODE_SYS: s.idx = BIDX_W'(0);
      MODE_PRIV:           s.idx = BIDX_W'(1);
      MODE_TRAP:           s.idx = BIDX_W'(2);
      MODE_INTR:           s.idx = BIDX_W'(3);
      MODE_EXT:            s.idx = BIDX_W'(4);
      default: begin
        s.valid = 1'b0;
        s.idx   = '0;
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/exc_cause_map.sv
module exc_cause_map
  import exc_entry_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [31:0] LO_BASE = 32'h0000_0000,
  parameter logic [31:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic [2:0]      cause_i,
  input  logic            hi_vec_i,
  output logic            legal_o,
  output logic [4:0]      mode_o,
  output logic [XLEN-1:0] vector_o
);

  logic [7:0]      offset;
  logic [XLEN-1:0] base;

  assign base = hi_vec_i ? XLEN'(HI_BASE) : XLEN'(LO_BASE);

  always_comb begin
    legal_o = 1'b1;
    mode_o  = MODE_PRIV;
    offset  = 8'h00;
    case (cause_i)
      CAUSE_SWCALL: begin mode_o = MODE_PRIV; offset = 8'h08; end
      CAUSE_IABORT: begin mode_o = MODE_TRAP; offset = 8'h0C; end
      CAUSE_DABORT: begin mode_o = MODE_TRAP; offset = 8'h10; end
      CAUSE_IRQ:    begin mode_o = MODE_INTR; offset = 8'h18; end
      default:      legal_o = 1'b0;
    endcase
  end

  assign vector_o = base + XLEN'(offset);

  always_comb begin
    if (legal_o) begin
      p_vec_aligned_r2: assert (vector_o[1:0] == 2'b00);
    end
  end

endmodule

// File: rtl/exc_bank_file.sv
module exc_bank_file
  import exc_entry_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] R29_BASE = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [BIDX_W-1:0] wr_idx_i,
  input  logic [XLEN-1:0]   wr_r29_i,
  input  logic [XLEN-1:0]   wr_r30_i,
  input  logic [XLEN-1:0]   wr_bsr_i,
  input  logic [BIDX_W-1:0] rd_idx_i,
  output logic [XLEN-1:0]   rd_r29_o
);

  logic [XLEN-1:0] r29_q [NUM_BANKS];
  logic [XLEN-1:0] r30_q [NUM_BANKS];
  logic [XLEN-1:0] bsr_q [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r29_q[g] <= XLEN'(R29_BASE) + XLEN'(g);
        r30_q[g] <= '0;
        bsr_q[g] <= '0;
      end else if (wr_en_i && (wr_idx_i == BIDX_W'(g))) begin
        r29_q[g] <= wr_r29_i;
        r30_q[g] <= wr_r30_i;
        bsr_q[g] <= wr_bsr_i;
      end
    end

    p_bank_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_idx_i == BIDX_W'(g)) |=>
        (r29_q[g] == $past(wr_r29_i) && r30_q[g] == $past(wr_r30_i)
         && bsr_q[g] == $past(wr_bsr_i)));
  end

  always_comb begin
    rd_r29_o = r29_q[0];
    for (int i = 1; i < NUM_BANKS; i++) begin
      if (rd_idx_i == BIDX_W'(i)) rd_r29_o = r29_q[i];
    end
  end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int          XLEN         = 32,
  parameter logic [4:0]  RESET_MODE   = 5'h10,
  parameter logic [31:0] RESET_STATUS = 32'h6000_0000,
  parameter logic [31:0] R29_BASE     = 32'h0000_1000,
  parameter logic [31:0] LO_BASE      = 32'h0000_0000,
  parameter logic [31:0] HI_BASE      = 32'hFFFF_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_valid_i,
  output logic            exc_ready_o,
  input  logic [2:0]      exc_cause_i,
  input  logic            hi_vec_i,
  input  logic [XLEN-1:0] exc_pc_i,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] saved_status_o,
  output logic [XLEN-1:0] r29_o,
  output logic [XLEN-1:0] r30_o,
  output logic [XLEN-1:0] r31_o,
  output logic            entry_done_o,
  output logic            bad_cause_o,
  output logic            mode_err_o
);

  localparam bank_sel_t       RST_SEL    = mode_to_bank(RESET_MODE);
  localparam logic [XLEN-1:0] RST_R29    = XLEN'(R29_BASE) + XLEN'(RST_SEL.idx);
  localparam logic [XLEN-1:0] RST_STATUS = {RESET_STATUS[XLEN-1:5], RESET_MODE};

  logic [XLEN-1:0] status_q, bsr_q, r29_q, r30_q, r31_q;
  logic            ready_q, done_q, bad_q;

  logic            cause_legal;
  logic [4:0]      new_mode;
  logic [XLEN-1:0] vector;
  bank_sel_t       cur_sel, new_sel;
  logic            accept, take, same_mode, swap;
  logic [XLEN-1:0] bank_r29;

  exc_cause_map #(
    .XLEN(XLEN), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)
  ) u_cause (
    .cause_i  (exc_cause_i),
    .hi_vec_i (hi_vec_i),
    .legal_o  (cause_legal),
    .mode_o   (new_mode),
    .vector_o (vector)
  );

  assign cur_sel   = mode_to_bank(status_q[4:0]);
  assign new_sel   = mode_to_bank(new_mode);
  assign accept    = exc_valid_i && ready_q;
  assign take      = accept && cause_legal && cur_sel.valid;
  assign same_mode = (new_mode == status_q[4:0]);
  assign swap      = take && !same_mode;

  exc_bank_file #(
    .XLEN(XLEN), .R29_BASE(R29_BASE)
  ) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (swap),
    .wr_idx_i (cur_sel.idx),
    .wr_r29_i (r29_q),
    .wr_r30_i (r30_q),
    .wr_bsr_i (bsr_q),
    .rd_idx_i (new_sel.idx),
    .rd_r29_o (bank_r29)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      done_q   <= 1'b0;
      bad_q    <= 1'b0;
      status_q <= RST_STATUS;
      bsr_q    <= '0;
      r29_q    <= RST_R29;
      r30_q    <= '0;
      r31_q    <= '0;
    end else begin
      ready_q <= 1'b1;
      done_q  <= take;
      bad_q   <= accept && !cause_legal;
      if (take) begin
        if (!same_mode) r29_q <= bank_r29;
        bsr_q    <= status_q;
        status_q <= {status_q[XLEN-1:INTDIS_BIT+1], 1'b1,
                     status_q[INTDIS_BIT-1:5], new_mode};
        r30_q    <= exc_pc_i;
        r31_q    <= vector;
      end
    end
  end

  assign exc_ready_o    = ready_q;
  assign status_o       = status_q;
  assign saved_status_o = bsr_q;
  assign r29_o          = r29_q;
  assign r30_o          = r30_q;
  assign r31_o          = r31_q;
  assign entry_done_o   = done_q;
  assign bad_cause_o    = bad_q;
  assign mode_err_o     = !cur_sel.valid;

  p_done_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> entry_done_o);
  p_intdis_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done_o |-> status_q[INTDIS_BIT]);
  p_return_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (r30_q == $past(exc_pc_i)));
  p_saved_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (bsr_q == $past(status_q)));
  p_same_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && same_mode) |=> $stable(r29_q));
  p_bad_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cause_o |-> ($stable(status_q) && $stable(r31_q) && !entry_done_o));
  p_mode_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err_o |-> !entry_done_o);

endmodule

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [2:0]  exc_cause = 3'd0;
  logic        hi_vec = 1'b0;
  logic [31:0] exc_pc = '0;

  logic        ready, done, bad, merr;
  logic [31:0] status, bsr, r29, r30, r31;
  logic        b_ready, b_done, b_bad, b_merr;
  logic [31:0] b_status, b_bsr, b_r29, b_r30, b_r31;

  int total = 0;
  int bad_cnt = 0;

  always #5 clk = ~clk;

  exc_entry_unit u_dut (
    .clk(clk), .rst_n(rst_n), .exc_valid_i(exc_valid), .exc_ready_o(ready),
    .exc_cause_i(exc_cause), .hi_vec_i(hi_vec), .exc_pc_i(exc_pc),
    .status_o(status), .saved_status_o(bsr), .r29_o(r29), .r30_o(r30),
    .r31_o(r31), .entry_done_o(done), .bad_cause_o(bad), .mode_err_o(merr)
  );

  exc_entry_unit #(.RESET_MODE(5'h05)) u_bad (
    .clk(clk), .rst_n(rst_n), .exc_valid_i(exc_valid), .exc_ready_o(b_ready),
    .exc_cause_i(exc_cause), .hi_vec_i(hi_vec), .exc_pc_i(exc_pc),
    .status_o(b_status), .saved_status_o(b_bsr), .r29_o(b_r29), .r30_o(b_r30),
    .r31_o(b_r31), .entry_done_o(b_done), .bad_cause_o(b_bad), .mode_err_o(b_merr)
  );

  // reference model state
  logic [31:0] m_status, m_bsr, m_r29, m_r30, m_r31;
  logic        m_ready, m_done, m_bad;
  logic [31:0] m_bank29 [5];

  function automatic int bank_of(input logic [4:0] m);
    case (m)
      5'h10, 5'h1F: return 0;
      5'h13: return 1;
      5'h17: return 2;
      5'h12: return 3;
      5'h1B: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad_cnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_status = 32'h6000_0010;
    m_bsr = '0; m_r29 = 32'h1000; m_r30 = '0; m_r31 = '0;
    m_ready = 1'b0; m_done = 1'b0; m_bad = 1'b0;
    for (int i = 0; i < 5; i++) m_bank29[i] = 32'h1000 + i;
  endtask

  task automatic compare_all();
    chk("R10 ready", {31'd0, ready}, {31'd0, m_ready});
    chk("R10 done", {31'd0, done}, {31'd0, m_done});
    chk("R8 bad_cause", {31'd0, bad}, {31'd0, m_bad});
    chk("R3 status", status, m_status);
    chk("R4 saved status", bsr, m_bsr);
    chk("R6 r29", r29, m_r29);
    chk("R5 r30", r30, m_r30);
    chk("R5 r31", r31, m_r31);
    chk("R9 mode_err main", {31'd0, merr}, 32'd0);
    chk("R9 mode_err flag", {31'd0, b_merr}, 32'd1);
    chk("R9 status unchanged", b_status, 32'h6000_0005);
    chk("R9 r31 unchanged", b_r31, 32'd0);
    chk("R9 no done", {31'd0, b_done}, 32'd0);
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic v, input logic [2:0] c, input logic h, input logic [31:0] pc);
    logic [4:0]  nm;
    logic [31:0] off;
    logic        legal, acc;
    int          ob, nb;
    exc_valid = v; exc_cause = c; hi_vec = h; exc_pc = pc;
    @(posedge clk);
    legal = 1'b1; nm = 5'h13; off = 0;
    case (c)
      3'd0: begin nm = 5'h13; off = 32'h08; end   // R1 swcall -> priv
      3'd1: begin nm = 5'h17; off = 32'h0C; end   // R1 iabort -> trap
      3'd2: begin nm = 5'h17; off = 32'h10; end   // R1 dabort -> trap
      3'd3: begin nm = 5'h12; off = 32'h18; end   // R1 irq -> intr
      default: legal = 1'b0;
    endcase
    acc = v && m_ready;
    m_done = acc && legal;
    m_bad = acc && !legal;
    if (acc && legal) begin
      ob = bank_of(m_status[4:0]);
      nb = bank_of(nm);
      if (nm != m_status[4:0]) begin
        m_bank29[ob] = m_r29;
        m_r29 = m_bank29[nb];
      end
      m_bsr = m_status;
      m_status = {m_status[31:8], 1'b1, m_status[6:5], nm};
      m_r30 = pc;
      m_r31 = (h ? 32'hFFFF_0000 : 32'h0) + off;  // R2
    end
    m_ready = 1'b1;
    @(negedge clk);
    compare_all();
  endtask

  logic wd_expired = 1'b0;
  initial begin
    #1_000_000;
    wd_expired = 1'b1;
    total++; bad_cnt++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad_cnt);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R11 reset state
    compare_all();
    chk("R11 r29 seed", r29, 32'h1000);
    chk("R11 bad-mode r29", b_r29, 32'h1000);
    rst_n = 1'b1;
    step(1'b0, 3'd0, 1'b0, 32'h0);            // R10 ready rises
    step(1'b0, 3'd2, 1'b1, 32'h44);           // idle with stray inputs
    step(1'b1, 3'd0, 1'b0, 32'h0000_0100);    // user -> priv, low base
    step(1'b0, 3'd0, 1'b0, 32'h0);            // done falls
    step(1'b1, 3'd3, 1'b1, 32'h0000_0200);    // priv -> intr, high base
    step(1'b1, 3'd2, 1'b0, 32'h0000_0300);    // intr -> trap, back to back
    step(1'b1, 3'd1, 1'b1, 32'h0000_0400);    // R7 trap -> trap
    step(1'b0, 3'd0, 1'b0, 32'h0);
    step(1'b1, 3'd5, 1'b0, 32'h0000_0500);    // R8 illegal cause
    step(1'b1, 3'd7, 1'b1, 32'h0000_0600);    // R8 illegal cause
    step(1'b1, 3'd0, 1'b1, 32'h0000_0700);    // trap -> priv, r29 reload
    step(1'b1, 3'd0, 1'b0, 32'h0000_0800);    // R7 priv -> priv
    step(1'b1, 3'd3, 1'b0, 32'h0000_0900);    // priv -> intr
    step(1'b0, 3'd0, 1'b0, 32'h0);
    chk("R6 r29 intr bank", r29, 32'h1003);
    chk("R1 final mode intr", {27'd0, status[4:0]}, 32'h12);
    if (!wd_expired) begin
      $display("test done: total=%0d bad=%0d", total, bad_cnt);
      $finish;
    end
  end

endmodule